// File: doc/BRIEF.md
# Free-Running Timer with Buffered Match

This peripheral timer has a 10-bit up counter that never stops while the timer is enabled. It also has two compare channels that work independently of each other. Each timer tick comes from one of three sources: the system clock divided by 2, the system clock divided by 16, or an external tick strobe. The external strobe is usually the output of another timer.

Each compare channel holds its compare value in two stages. The host writes a high byte and then a low byte into a holding stage, and the low-byte write commits the pair. The committed pair waits there until the channel's match register is free. It then moves across on the next timer tick, and the match register becomes valid. When the counter steps onto a valid match value, three things happen: the channel emits a single-clock pulse, it latches a sticky interrupt flag, and it drops the match value back to invalid. Every loaded value therefore fires exactly once. A queued value refills the channel on the following tick.

The host reaches the block through a small byte-wide register port. Reading the control/status register clears the flags. Re-arming a channel takes only a new low byte, because the high byte is kept.

Top module: `frt_match_timer`

## Requirements
- R1: Reset sets `count` to 0. Each timer tick adds one, and 1023 wraps to 0. Reading address 1 returns count[7:0], and reading address 2 returns count[9:8] in bits 1:0. `reg_rdata` is registered and updates one clock after a read strobe.
- R2: With `ext_sel`=0 and `div_sel`=0 and the timer enabled, `count` advances once every 2 clocks.
- R3: With `ext_sel`=0 and `div_sel`=1 and the timer enabled, `count` advances once every 16 clocks.
- R4: With `ext_sel`=1, `count` advances exactly on the clock edges at which `ext_tick` is high, and the divided sources have no effect.
- R5: `match_pulse[c]` is high for exactly one clock, in the cycle in which `count` first equals channel c's valid match value. No further pulse occurs while `count` rests there, and an invalid match value never pulses.
- R6: After reset both match values are invalid. Channel c's high byte is written at address 4+2c (bits 1:0), and its low byte is written at address 5+2c. The low-byte write commits {held high, low} as pending. While the match value is invalid, a pending value loads on the next tick edge and becomes valid. Reading address 4+2c returns {valid, pending, 4'b0, match[9:8]}, and reading address 5+2c returns match[7:0].
- R7: A commit while the match value is valid stays pending and leaves the active match value unchanged. Queued values fire in the order they were written.
- R8: A match invalidates the value on the same edge. A pending value loads on the following tick, never on the matching edge. With nothing pending, the channel stays silent, even across counter wraps.
- R9: The held high byte is retained, so writing only the low byte re-arms the channel with the previous high byte.
- R10: Writing address 0 sets enable (bit 0) and channel interrupt enables (bits 2:1). Reading address 0 returns enable in bit 0, the interrupt enables in bits 2:1 and the sticky match flags in bits 5:4, and that read clears the flags (a match on the same edge still sets its flag). `irq` is the OR of the flags gated by their enables.
- R11: With enable cleared, `count` holds and no pending value transfers, whatever the tick source does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| div_sel | input | 1 | 0: divide-by-2 tick, 1: divide-by-16 tick |
| ext_sel | input | 1 | 1: count on external tick strobe |
| ext_tick | input | 1 | External tick strobe, one clock wide per tick |
| count | output | 10 | Current counter value |
| match_pulse | output | 2 | Per-channel one-clock match pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a channel that has just matched and still holds a queued value. The bench must show that the queued value stays out on the matching edge and loads on the very next tick, and that it fires after the first value and not before. The bench reaches this state by switching to the external tick source, so it controls every counter step. It loads one value, queues a second while the first is valid, and steps the counter one tick at a time around both match points, reading the channel status between steps. Long constrained-random runs then mix register traffic, read-clears and all three tick sources against a cycle-level model computed in the bench.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
package frt_pkg;
  // Register address map shared by decode and readback
  localparam int unsigned ADDR_CTRL    = 0;
  localparam int unsigned ADDR_CNT_LO  = 1;
  localparam int unsigned ADDR_CNT_HI  = 2;
  localparam int unsigned ADDR_CH_BASE = 4;  // channel c: hi at base+2c, lo at base+2c+1
  localparam int unsigned FLAG_LSB     = 4;  // status flags start here in the control read
endpackage

// File: rtl/frt_tick_gen.sv
`timescale 1ns/1ps
module frt_tick_gen #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic div_sel,
  input  logic ext_sel,
  input  logic ext_tick,
  output logic tick
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam int FW = $clog2(DIV_FAST);

  logic [PW-1:0] presc;
  logic          fast_hit;
  logic          slow_hit;

  always_ff @(posedge clk) begin
    if (rst || !en) presc <= '0;
    else            presc <= presc + 1'b1;
  end

  assign fast_hit = &presc[FW-1:0];
  assign slow_hit = &presc;
  assign tick     = en && (ext_sel ? ext_tick : (div_sel ? slow_hit : fast_hit));

  // R11: no tick may be produced while disabled
  p_no_tick_disabled_r11: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick);
endmodule

// File: rtl/frt_counter.sv
`timescale 1ns/1ps
module frt_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cnt_next
);
  assign cnt_next = count + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= cnt_next;
  end

  // R1: count moves only on a tick, by exactly one with wrap
  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
  p_step_one_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count == $past(count) + {{(CNT_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/frt_match_chan.sv
`timescale 1ns/1ps
module frt_match_chan #(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic             clr_flag,
  output logic             pulse,
  output logic             flag,
  output logic             valid,
  output logic             pend,
  output logic [CNT_W-1:0] mval
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [HI_W-1:0]   hold_hi;
  logic [DATA_W-1:0] hold_lo;
  logic              xfer;
  logic              hit;

  // Transfer only into an empty slot; match only against a loaded value
  assign xfer = tick && !valid && pend;
  assign hit  = tick && valid && (cnt_next == mval);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_hi <= '0;
      hold_lo <= '0;
      pend    <= 1'b0;
      valid   <= 1'b0;
      mval    <= '0;
      pulse   <= 1'b0;
      flag    <= 1'b0;
    end else begin
      pulse <= hit;
      flag  <= (flag && !clr_flag) || hit;
      pend  <= (pend && !xfer) || wr_lo;
      if (wr_hi) hold_hi <= wdata[HI_W-1:0];
      if (wr_lo) hold_lo <= wdata;
      if (xfer) begin
        mval  <= {hold_hi, hold_lo};
        valid <= 1'b1;
      end else if (hit) begin
        valid <= 1'b0;
      end
    end
  end

  // R5: pulse lasts one clock
  p_one_clock_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  // R8: a fired value is no longer valid
  p_invalid_after_hit_r8: assert property (@(posedge clk) disable iff (rst)
    pulse |-> !valid);
  // R7: an active value is never overwritten
  p_active_stable_r7: assert property (@(posedge clk) disable iff (rst)
    valid |=> $stable(mval));
  // R6: loads happen only on tick edges
  p_load_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(tick));
  // R10: every pulse leaves a flag behind
  p_flag_with_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    pulse |-> flag);
endmodule

// File: rtl/frt_match_timer.sv
`timescale 1ns/1ps
module frt_match_timer
  import frt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int NUM_CH   = 2,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              div_sel,
  input  logic              ext_sel,
  input  logic              ext_tick,
  output logic [CNT_W-1:0]  count,
  output logic [NUM_CH-1:0] match_pulse,
  output logic              irq
);
  localparam int HI_W = CNT_W - DATA_W;

  logic              en;
  logic [NUM_CH-1:0] ie;
  logic              tick;
  logic [CNT_W-1:0]  cnt_next;
  logic              ctrl_wr;
  logic              ctrl_rd;
  logic [NUM_CH-1:0] ch_wr_hi;
  logic [NUM_CH-1:0] ch_wr_lo;
  logic [NUM_CH-1:0] ch_flag;
  logic [NUM_CH-1:0] ch_valid;
  logic [NUM_CH-1:0] ch_pend;
  logic [CNT_W-1:0]  ch_mval [NUM_CH];
  logic [DATA_W-1:0] rd_val;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
  assign ctrl_rd = reg_rd && (reg_addr == ADDR_W'(ADDR_CTRL));

  frt_tick_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) tick_i (
    .clk(clk), .rst(rst), .en(en), .div_sel(div_sel),
    .ext_sel(ext_sel), .ext_tick(ext_tick), .tick(tick)
  );

  frt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .count(count), .cnt_next(cnt_next)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_wr_hi[g] = reg_wr && (reg_addr == ADDR_W'(ADDR_CH_BASE + 2*g));
    assign ch_wr_lo[g] = reg_wr && (reg_addr == ADDR_W'(ADDR_CH_BASE + 2*g + 1));

    frt_match_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chan_i (
      .clk(clk), .rst(rst), .tick(tick), .cnt_next(cnt_next),
      .wr_hi(ch_wr_hi[g]), .wr_lo(ch_wr_lo[g]), .wdata(reg_wdata),
      .clr_flag(ctrl_rd), .pulse(match_pulse[g]), .flag(ch_flag[g]),
      .valid(ch_valid[g]), .pend(ch_pend[g]), .mval(ch_mval[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
      ie <= '0;
    end else if (ctrl_wr) begin
      {ie, en} <= reg_wdata[NUM_CH:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
      rd_val[0]                   = en;
      rd_val[NUM_CH:1]            = ie;
      rd_val[FLAG_LSB +: NUM_CH]  = ch_flag;
    end else if (reg_addr == ADDR_W'(ADDR_CNT_LO)) begin
      rd_val = count[DATA_W-1:0];
    end else if (reg_addr == ADDR_W'(ADDR_CNT_HI)) begin
      rd_val[HI_W-1:0] = count[CNT_W-1:DATA_W];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(ADDR_CH_BASE + 2*c)) begin
        rd_val[DATA_W-1] = ch_valid[c];
        rd_val[DATA_W-2] = ch_pend[c];
        rd_val[HI_W-1:0] = ch_mval[c][CNT_W-1:DATA_W];
      end else if (reg_addr == ADDR_W'(ADDR_CH_BASE + 2*c + 1)) begin
        rd_val = ch_mval[c][DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  assign irq = |(ch_flag & ie);

  // R11: disabled timer keeps its count
  p_disabled_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));
  // R10: a control read leaves no old flag set unless a new pulse arrived
  p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> ((ch_flag & ~match_pulse) == '0));
endmodule

// File: tb/frt_match_timer_tb.sv
`timescale 1ns/1ps
module frt_match_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       div_sel, ext_sel, ext_tick;
  logic [9:0] count;
  logic [1:0] match_pulse;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int pulse_cnt0 = 0;

  always #10 clk = ~clk;  // 50 MHz

  frt_match_timer dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .div_sel(div_sel), .ext_sel(ext_sel), .ext_tick(ext_tick),
    .count(count), .match_pulse(match_pulse), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic       m_live;
  logic       m_en;
  logic [1:0] m_ie;
  logic [9:0] m_cnt;
  logic [3:0] m_presc;
  logic [1:0] m_hh   [2];
  logic [7:0] m_hl   [2];
  logic [9:0] m_mv   [2];
  logic [1:0] m_pend, m_val, m_flag, m_pulse;
  logic [7:0] m_rdata;
  logic       m_tk;
  logic [9:0] m_nc;

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {2'b00, m_flag, 1'b0, m_ie, m_en};
      3'd1: return m_cnt[7:0];
      3'd2: return {6'b0, m_cnt[9:8]};
      3'd4: return {m_val[0], m_pend[0], 4'b0, m_mv[0][9:8]};
      3'd5: return m_mv[0][7:0];
      3'd6: return {m_val[1], m_pend[1], 4'b0, m_mv[1][9:8]};
      3'd7: return m_mv[1][7:0];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_live = 0; m_en = 0; m_ie = 0; m_cnt = 0; m_presc = 0;
      m_pend = 0; m_val = 0; m_flag = 0; m_pulse = 0; m_rdata = 0;
      for (int c = 0; c < 2; c++) begin m_hh[c] = 0; m_hl[c] = 0; m_mv[c] = 0; end
    end else begin
      m_tk = m_en && (ext_sel ? ext_tick : (div_sel ? (m_presc == 4'hF) : m_presc[0]));
      m_nc = m_cnt + 10'd1;
      if (reg_rd) m_rdata = exp_read(reg_addr);
      for (int c = 0; c < 2; c++) begin
        logic xf, ht;
        xf = m_tk && !m_val[c] && m_pend[c];
        ht = m_tk && m_val[c] && (m_nc == m_mv[c]);
        m_pulse[c] = ht;
        m_flag[c]  = (m_flag[c] && !(reg_rd && reg_addr == 3'd0)) || ht;
        if (xf) begin m_mv[c] = {m_hh[c], m_hl[c]}; m_val[c] = 1; end
        else if (ht) m_val[c] = 0;
        m_pend[c] = (m_pend[c] && !xf) || (reg_wr && reg_addr == 3'(5 + 2*c));
        if (reg_wr && reg_addr == 3'(4 + 2*c)) m_hh[c] = reg_wdata[1:0];
        if (reg_wr && reg_addr == 3'(5 + 2*c)) m_hl[c] = reg_wdata;
      end
      if (m_tk) m_cnt = m_nc;
      m_presc = m_en ? m_presc + 4'd1 : 4'd0;
      if (reg_wr && reg_addr == 3'd0) {m_ie, m_en} = reg_wdata[2:0];
      m_live = 1;
    end
    #5;
    if (m_live && !rst) begin
      check("R1 model count", count, m_cnt);
      check("R5 model pulse", match_pulse, m_pulse);
      check("R10 model irq", irq, |(m_flag & m_ie));
      check("R6 model rdata", reg_rdata, m_rdata);
    end
  end

  always @(negedge clk) if (!rst && match_pulse[0]) pulse_cnt0++;

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask

  task automatic etick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); ext_tick = 1; end
    @(negedge clk); ext_tick = 0;
  endtask

  task automatic goto_cnt(input int tgt);
    int d;
    d = (tgt - int'(count) + 1024) % 1024;
    if (d != 0) etick(d);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int c0, p0;
    void'($urandom(32'd4711));
    rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    div_sel = 0; ext_sel = 0; ext_tick = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset count", count, 0);
    check("R5 reset pulse", match_pulse, 0);
    check("R10 reset irq", irq, 0);
    rd(3'd0, v); check("R10 reset ctrl", v, 0);

    // R2: divide-by-2
    wr(3'd0, 8'h03);
    c0 = count; repeat (20) @(negedge clk);
    check("R2 div2 rate", count - c0, 10);
    // R3: divide-by-16
    div_sel = 1; c0 = count; repeat (64) @(negedge clk);
    check("R3 div16 rate", count - c0, 4);
    // R4: external ticks only
    ext_sel = 1; div_sel = 0; repeat (3) @(negedge clk);
    c0 = count; repeat (9) @(negedge clk); etick(5); repeat (6) @(negedge clk);
    check("R4 ext rate", count - c0, 5);
    rd(3'd1, v); check("R1 count lo readback", v, count[7:0]);
    rd(3'd2, v); check("R1 count hi readback", v, {6'b0, count[9:8]});

    // R11: disabled
    wr(3'd0, 8'h02);
    c0 = count; etick(6);
    check("R11 count holds", count, c0);
    wr(3'd5, 8'h77); etick(3);
    rd(3'd4, v); check("R11 no transfer", v, 8'h40);
    wr(3'd0, 8'h03);

    // R6: load on next tick
    wr(3'd4, 8'h01); wr(3'd5, 8'h20);
    rd(3'd4, v); check("R6 pending before tick", v, 8'h40);
    etick(1);
    rd(3'd4, v); check("R6 valid after tick", v, 8'h81);
    rd(3'd5, v); check("R6 match lo", v, 8'h20);

    // R5: pulse at 0x120
    goto_cnt(10'h11F); etick(1);
    check("R5 pulse high", match_pulse[0], 1);
    check("R5 count at match", count, 10'h120);
    @(negedge clk); check("R5 pulse one clock", match_pulse[0], 0);
    check("R10 irq set", irq, 1);
    rd(3'd4, v); check("R8 invalid after match", v, 8'h01);

    // R7: queueing while valid
    wr(3'd5, 8'h30); etick(1);
    wr(3'd5, 8'h40);
    rd(3'd4, v); check("R7 valid and pending", v, 8'hC1);
    rd(3'd5, v); check("R7 active undisturbed", v, 8'h30);
    goto_cnt(10'h12F); etick(1);
    check("R7 first value fires", match_pulse[0], 1);
    rd(3'd4, v); check("R8 no load on match edge", v, 8'h41);
    etick(1);
    rd(3'd4, v); check("R8 load on next tick", v, 8'h81);
    rd(3'd5, v); check("R8 queued lo", v, 8'h40);
    goto_cnt(10'h13F); etick(1);
    check("R7 queued value fires", match_pulse[0], 1);

    // R8: no repeat across a wrap
    @(negedge clk);
    p0 = pulse_cnt0; etick(1024);
    check("R8 no repeat pulses", pulse_cnt0 - p0, 0);
    check("R8 count after wrap", count, 10'h140);

    // R9: high byte retained
    wr(3'd5, 8'h50); etick(1);
    rd(3'd4, v); check("R9 high retained", v, 8'h81);
    rd(3'd5, v); check("R9 new lo", v, 8'h50);
    goto_cnt(10'h14F); etick(1);
    check("R9 rearmed pulse", match_pulse[0], 1);

    // R10: read clears
    @(negedge clk);
    check("R10 irq before read", irq, 1);
    rd(3'd0, v); check("R10 status with flag", v, 8'h13);
    check("R10 irq after read", irq, 0);
    rd(3'd0, v); check("R10 flag cleared", v, 8'h03);

    // Constrained random against model
    for (int i = 0; i < 6000; i++) begin
      int r, a;
      @(negedge clk);
      r = $urandom % 16; a = $urandom % 8;
      reg_wr = (r < 2); reg_rd = (r >= 2 && r < 4);
      reg_addr = 3'(a);
      if (a == 0) reg_wdata = {5'b0, 2'($urandom), 1'(($urandom % 8) != 0)};
      else        reg_wdata = 8'($urandom);
      ext_tick = 1'($urandom);
      if ($urandom % 64 == 0) ext_sel = 1'($urandom);
      if ($urandom % 64 == 0) div_sel = 1'($urandom);
    end
    @(negedge clk); reg_wr = 0; reg_rd = 0; ext_tick = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule